// File: doc/BRIEF.md
# Configurable UART Frame Transceiver

This block is a full-duplex asynchronous serial transceiver for 8-bit character frames. A 3-bit mode field picks the frame layout. Code `3'b001` sends and receives eight plain data bits. Code `3'b011` carries seven data bits plus a parity bit, which the transmitter builds by itself. Each frame is framed by a low start bit and one or two high stop bits. Data goes least significant bit first.

A programmable divider produces a tick at 16 times the baud rate. The transmitter holds each bit for 16 ticks. The receiver synchronises the line and confirms the start bit halfway through it. It then samples every later bit at its centre. Parity and framing faults set sticky flags, which only an explicit clear strobe resets. Every fault also produces a one-cycle error interrupt request.

Top module: `uart_frame_xcvr`

## Requirements
- R1: During and right after reset, `txd` is 1, and `tx_busy`, `rx_valid`, `par_err`, `frm_err` and `err_irq` are 0.
- R2: With `mode`=3'b001, a write sends a low start bit, then data bits 0..7 in that order, then a high stop bit. Each bit lasts 16*(`baud_div`+1) clock cycles.
- R3: With `mode`=3'b011, the eighth transmitted data slot carries generated parity in place of data bit 7. With `par_odd`=0 the parity is 1 exactly when data bits 6..0 hold an odd number of ones. With `par_odd`=1 it is the inverse.
- R4: With `two_stop`=1 the frame carries two stop bits (11 bits), and with 0 it carries one (10 bits). `tx_busy` stays 1 until the last stop bit has ended.
- R5: `tx_busy` rises only in the cycle after a `tx_wr`. A `tx_wr` while `tx_busy` is 1 is ignored: the running frame is unchanged and no further frame follows.
- R6: After each received frame, `rx_data` holds the eight bits that followed the start bit (first bit in bit 0), and `rx_valid` pulses high for exactly one cycle.
- R7: With `mode`=3'b011, `rx_data[6:0]` holds the seven data bits and `rx_data[7]` holds the received parity bit as it arrived.
- R8: With `mode`=3'b011 and `par_en`=1, a received parity bit that differs from the R3 rule sets `par_err`. In that same cycle `err_irq` and `rx_valid` are high.
- R9: No parity error is flagged when `par_en`=0, and none is flagged in `mode`=3'b001 whatever `par_en` is.
- R10: A first stop bit sampled as 0 sets `frm_err` and raises `err_irq`, and `rx_valid` still pulses for that frame.
- R11: `par_err` and `frm_err` stay set until `err_clr` is 1. Setting by a new fault takes precedence over the clear.
- R12: The start bit appears on `txd` in the same cycle that `tx_busy` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 3 | Frame layout code: 3'b001 eight data bits, 3'b011 seven data bits plus parity |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| par_en | input | 1 | Enables the receive parity check |
| two_stop | input | 1 | 1 selects two stop bits on transmit |
| baud_div | input | 16 | Oversample tick period minus one, in clock cycles |
| tx_data | input | 8 | Character to send |
| tx_wr | input | 1 | Write strobe for `tx_data` |
| tx_busy | output | 1 | A frame is being sent |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line |
| rx_data | output | 8 | Last received character |
| rx_valid | output | 1 | One-cycle pulse per received frame |
| par_err | output | 1 | Sticky parity error flag |
| frm_err | output | 1 | Sticky framing error flag |
| err_irq | output | 1 | One-cycle error interrupt request |
| err_clr | input | 1 | Clears both error flags |

## Verification
The vector table sends characters through a loopback in both layouts, with even and odd parity and with both stop-bit counts. Characters whose bit 7 is 1 show that parity replaces data bit 7 in the seven-bit layout, and the same seven bits under both parity senses show that the parity sense is inverted. Directed serial patterns feed the receiver a wrong parity bit with the check on, with the check off, and in eight-bit mode. This separates flagging from masking. A low stop bit, a write during a frame, and a good frame following an error probe framing, write rejection and flag stickiness.

// File: rtl/uart_frame_pkg.sv
package uart_frame_pkg;
  localparam int CHAR_W = 8;
  localparam int OSR    = 16;
  localparam logic [2:0] MODE_8D = 3'b001;
  localparam logic [2:0] MODE_7P = 3'b011;

  // generated parity: even -> xor of the seven bits, odd -> its inverse
  function automatic logic par_gen(input logic [CHAR_W-2:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // total bits on the line: start + character + stop bits
  function automatic logic [3:0] frame_bits(input logic two);
    return two ? 4'd11 : 4'd10;
  endfunction
endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              seven_par,
  input  logic              par_odd,
  input  logic              two_stop,
  input  logic [CHAR_W-1:0] data,
  input  logic              wr,
  output logic              txd,
  output logic              busy,
  output logic              start_ev
);
  localparam int PH_W = $clog2(OSR);
  localparam int SH_W = CHAR_W + 3;

  logic [SH_W-1:0] sh;
  logic [3:0]      bits_left;
  logic [PH_W-1:0] ph;
  logic            top_bit;
  logic            bit_end;

  assign start_ev = wr && !busy;
  assign top_bit  = seven_par ? par_gen(data[CHAR_W-2:0], par_odd) : data[CHAR_W-1];
  assign bit_end  = busy && tick && (ph == PH_W'(OSR-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '1;
      bits_left <= '0;
      ph        <= '0;
      busy      <= 1'b0;
    end else if (start_ev) begin
      sh        <= {2'b11, top_bit, data[CHAR_W-2:0], 1'b0};
      bits_left <= frame_bits(two_stop);
      ph        <= '0;
      busy      <= 1'b1;
    end else if (bit_end) begin
      ph        <= '0;
      sh        <= {1'b1, sh[SH_W-1:1]};
      bits_left <= bits_left - 1'b1;
      if (bits_left == 4'd1) busy <= 1'b0;
    end else if (busy && tick) begin
      ph <= ph + 1'b1;
    end
  end

  assign txd = busy ? sh[0] : 1'b1;
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              seven_par,
  input  logic              par_odd,
  input  logic              par_en,
  input  logic              err_clr,
  output logic [CHAR_W-1:0] data,
  output logic              valid,
  output logic              par_err,
  output logic              frm_err,
  output logic              err_irq,
  output logic              done_ev,
  output logic              par_fail_ev,
  output logic              frm_fail_ev
);
  localparam int PH_W = $clog2(OSR);
  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rx_state_e;

  rx_state_e         st;
  logic              s1, s2;
  logic [PH_W-1:0]   ph;
  logic [2:0]        nbit;
  logic [CHAR_W-1:0] sh;
  logic              centre;

  assign centre      = tick && (ph == PH_W'(OSR-1));
  assign done_ev     = (st == S_STOP) && centre;
  assign par_fail_ev = done_ev && seven_par && par_en &&
                       (sh[CHAR_W-1] != par_gen(sh[CHAR_W-2:0], par_odd));
  assign frm_fail_ev = done_ev && !s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      ph   <= '0;
      nbit <= '0;
      sh   <= '0;
    end else if (tick) begin
      case (st)
        S_IDLE: if (!s2) begin
          st <= S_START;
          ph <= '0;
        end
        S_START: if (ph == PH_W'(OSR/2 - 1)) begin
          ph   <= '0;
          nbit <= '0;
          st   <= s2 ? S_IDLE : S_DATA;
        end else begin
          ph <= ph + 1'b1;
        end
        S_DATA: if (centre) begin
          ph <= '0;
          sh <= {s2, sh[CHAR_W-1:1]};
          if (nbit == 3'd7) st <= S_STOP;
          else nbit <= nbit + 1'b1;
        end else begin
          ph <= ph + 1'b1;
        end
        default: if (centre) begin
          ph <= '0;
          st <= S_IDLE;
        end else begin
          ph <= ph + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data    <= '0;
      valid   <= 1'b0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
      err_irq <= 1'b0;
    end else begin
      valid   <= done_ev;
      err_irq <= par_fail_ev || frm_fail_ev;
      if (done_ev) data <= sh;
      if (err_clr) begin
        par_err <= 1'b0;
        frm_err <= 1'b0;
      end
      if (par_fail_ev) par_err <= 1'b1;
      if (frm_fail_ev) frm_err <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_frame_xcvr.sv
module uart_frame_xcvr
  import uart_frame_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic             par_odd,
  input  logic             par_en,
  input  logic             two_stop,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [7:0]       tx_data,
  input  logic             tx_wr,
  output logic             tx_busy,
  output logic             txd,
  input  logic             rxd,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             par_err,
  output logic             frm_err,
  output logic             err_irq,
  input  logic             err_clr
);
  logic tick;
  logic seven_par;
  logic tx_start_ev;
  logic rx_done_ev, rx_par_fail_ev, rx_frm_fail_ev;

  assign seven_par = (mode == MODE_7P);

  uart_baud_gen #(.DIV_W(DIV_W)) i_baud (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
  );

  uart_frame_tx i_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .seven_par(seven_par),
    .par_odd(par_odd), .two_stop(two_stop), .data(tx_data), .wr(tx_wr),
    .txd(txd), .busy(tx_busy), .start_ev(tx_start_ev)
  );

  uart_frame_rx i_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .seven_par(seven_par),
    .par_odd(par_odd), .par_en(par_en), .err_clr(err_clr),
    .data(rx_data), .valid(rx_valid), .par_err(par_err), .frm_err(frm_err),
    .err_irq(err_irq), .done_ev(rx_done_ev), .par_fail_ev(rx_par_fail_ev),
    .frm_fail_ev(rx_frm_fail_ev)
  );
endmodule

// File: rtl/uart_frame_chk.sv
module uart_frame_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       tx_wr,
  input logic       tx_busy,
  input logic       txd,
  input logic       rx_valid,
  input logic       par_err,
  input logic       frm_err,
  input logic       err_irq,
  input logic       err_clr
);
  a_r12_start_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd);
  a_r5_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(tx_wr));
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r8_par_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_err) |-> (err_irq && rx_valid));
  a_r10_frm_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frm_err) |-> (err_irq && rx_valid));
  a_r11_par_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !err_clr) |=> par_err);
  a_r11_frm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_err && !err_clr) |=> frm_err);
  a_r9_no_check_8bit: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && mode == 3'b001) |-> !$rose(par_err));
endmodule

bind uart_frame_xcvr uart_frame_chk i_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .tx_wr(tx_wr), .tx_busy(tx_busy),
  .txd(txd), .rx_valid(rx_valid), .par_err(par_err), .frm_err(frm_err),
  .err_irq(err_irq), .err_clr(err_clr)
);

// File: tb/test_uart_frame_xcvr.sv
`timescale 1ns/1ps
module test_uart_frame_xcvr;
  localparam int DIV = 1;
  localparam int BIT = 16 * (DIV + 1);
  localparam int NV  = 7;
  // {seven_par, odd, two_stop, data}
  localparam logic [10:0] VEC [NV] = '{
    {3'b000, 8'hA5}, {3'b001, 8'h3C}, {3'b100, 8'h53}, {3'b110, 8'h53},
    {3'b100, 8'h07}, {3'b111, 8'h7F}, {3'b110, 8'hC5}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode = 3'b001;
  logic par_odd = 1'b0, par_en = 1'b1, two_stop = 1'b0;
  logic [15:0] baud_div = 16'(DIV);
  logic [7:0] tx_data = '0;
  logic tx_wr = 1'b0, err_clr = 1'b0;
  logic loopback = 1'b1, rxd_drv = 1'b1;
  logic rxd;
  logic tx_busy, txd, rx_valid, par_err, frm_err, err_irq;
  logic [7:0] rx_data;

  int checks = 0, fails = 0, rx_cnt = 0;
  logic [7:0] cap_d;
  logic cap_pe, cap_fe, cap_irq;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign rxd = loopback ? txd : rxd_drv;

  uart_frame_xcvr i_uart_frame_xcvr (
    .clk(clk), .rst_n(rst_n), .mode(mode), .par_odd(par_odd), .par_en(par_en),
    .two_stop(two_stop), .baud_div(baud_div), .tx_data(tx_data), .tx_wr(tx_wr),
    .tx_busy(tx_busy), .txd(txd), .rxd(rxd), .rx_data(rx_data),
    .rx_valid(rx_valid), .par_err(par_err), .frm_err(frm_err),
    .err_irq(err_irq), .err_clr(err_clr)
  );

  always @(negedge clk) if (rx_valid) begin
    rx_cnt++;
    cap_d = rx_data; cap_pe = par_err; cap_fe = frm_err; cap_irq = err_irq;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expect8(input logic sp, input logic odd, input logic [7:0] d);
    logic p;
    p = ($countones(d[6:0]) % 2 == 1) ? ~odd : odd;
    return sp ? {p, d[6:0]} : d;
  endfunction

  task automatic write(input logic [7:0] d);
    @(negedge clk); tx_data = d; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic wait_fall();
    for (int i = 0; i < 300; i++) begin
      if (!txd) break;
      @(negedge clk);
    end
  endtask

  task automatic capture(output logic [9:0] got);
    wait_fall();
    repeat (BIT / 2) @(negedge clk);
    got[0] = txd;
    for (int i = 1; i < 10; i++) begin
      repeat (BIT) @(negedge clk);
      got[i] = txd;
    end
  endtask

  task automatic wait_rx(input int n0);
    for (int i = 0; i < 2000; i++) begin
      if (rx_cnt > n0) break;
      @(negedge clk);
    end
  endtask

  task automatic drive(input logic [7:0] b, input logic stopb);
    @(negedge clk); rxd_drv = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd_drv = b[i];
      repeat (BIT) @(negedge clk);
    end
    rxd_drv = stopb;
    repeat (BIT) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic clear();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [9:0] got;
    logic [7:0] e8;
    int n0;
    bit irq_seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1 && tx_busy == 1'b0, "R1 tx reset", {txd, tx_busy}, 2'b10);
    chk({rx_valid, par_err, frm_err, err_irq} == 4'b0, "R1 rx reset",
        {rx_valid, par_err, frm_err, err_irq}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(txd == 1'b1 && tx_busy == 1'b0, "R1 after reset", {txd, tx_busy}, 2'b10);

    // table: R2 R3 R4 R6 R7 via loopback
    for (int v = 0; v < NV; v++) begin
      mode = VEC[v][10] ? 3'b011 : 3'b001;
      par_odd = VEC[v][9]; two_stop = VEC[v][8]; par_en = 1'b1;
      e8 = expect8(VEC[v][10], VEC[v][9], VEC[v][7:0]);
      n0 = rx_cnt;
      write(VEC[v][7:0]);
      capture(got);
      chk(got == {1'b1, e8, 1'b0}, VEC[v][10] ? "R3 tx frame" : "R2 tx frame",
          got, {1'b1, e8, 1'b0});
      wait_rx(n0);
      chk(rx_cnt == n0 + 1 && cap_d == e8, VEC[v][10] ? "R7 rx data" : "R6 rx data",
          cap_d, e8);
      chk(cap_pe == 1'b0, "R9 no parity error on good frame", cap_pe, 0);
      repeat (3 * BIT) @(negedge clk);
    end

    // R4 stop bit length
    mode = 3'b001; two_stop = 1'b1;
    write(8'hFF); wait_fall();
    repeat (BIT / 2 + 10 * BIT) @(negedge clk);
    chk(tx_busy == 1'b1 && txd == 1'b1, "R4 second stop bit", {tx_busy, txd}, 2'b11);
    repeat (2 * BIT) @(negedge clk);
    two_stop = 1'b0;
    write(8'hFF); wait_fall();
    repeat (BIT / 2 + 10 * BIT) @(negedge clk);
    chk(tx_busy == 1'b0 && txd == 1'b1, "R4 single stop ends", {tx_busy, txd}, 2'b01);
    repeat (2 * BIT) @(negedge clk);

    // R5 write while busy ignored
    n0 = rx_cnt;
    write(8'h5A);
    repeat (BIT * 3) @(negedge clk);
    chk(tx_busy == 1'b1, "R5 busy during frame", tx_busy, 1);
    write(8'hFF);
    wait_rx(n0);
    repeat (20 * BIT) @(negedge clk);
    chk(rx_cnt == n0 + 1 && cap_d == 8'h5A, "R5 second write ignored", cap_d, 8'h5A);
    chk(tx_busy == 1'b0 && txd == 1'b1, "R5 idle after frame", {tx_busy, txd}, 2'b01);

    // R8 parity error (7-bit even, data 0x01 needs parity 1, send 0)
    loopback = 1'b0; mode = 3'b011; par_odd = 1'b0; par_en = 1'b1;
    n0 = rx_cnt; irq_seen = 0;
    fork
      drive(8'h01, 1'b1);
      for (int i = 0; i < 12 * BIT; i++) begin
        @(negedge clk); if (err_irq) irq_seen = 1;
      end
    join
    wait_rx(n0);
    chk(par_err == 1'b1 && cap_pe == 1'b1 && cap_irq == 1'b1, "R8 parity error flagged",
        {par_err, cap_irq}, 2'b11);
    chk(irq_seen && cap_d == 8'h01 && frm_err == 1'b0, "R8 irq and data", cap_d, 8'h01);

    // R11 sticky, then clear
    n0 = rx_cnt;
    drive(8'h81, 1'b1);
    wait_rx(n0);
    chk(par_err == 1'b1 && cap_d == 8'h81, "R11 parity flag sticky", par_err, 1);
    clear();
    chk(par_err == 1'b0, "R11 cleared by strobe", par_err, 0);

    // R9 check disabled / 8-bit mode
    par_en = 1'b0; n0 = rx_cnt;
    drive(8'h01, 1'b1); wait_rx(n0);
    chk(par_err == 1'b0 && cap_d == 8'h01, "R9 check disabled", par_err, 0);
    par_en = 1'b1; mode = 3'b001; n0 = rx_cnt;
    drive(8'h01, 1'b1); wait_rx(n0);
    chk(par_err == 1'b0 && cap_d == 8'h01, "R9 8-bit mode no check", par_err, 0);

    // R10 framing error
    n0 = rx_cnt;
    drive(8'h3C, 1'b0); wait_rx(n0);
    chk(frm_err == 1'b1 && cap_fe == 1'b1 && cap_irq == 1'b1, "R10 framing error",
        {frm_err, cap_irq}, 2'b11);
    chk(cap_d == 8'h3C, "R10 data still delivered", cap_d, 8'h3C);
    repeat (25 * BIT) @(negedge clk);
    chk(frm_err == 1'b1, "R11 framing flag sticky", frm_err, 1);
    clear();
    chk(frm_err == 1'b0, "R11 framing flag cleared", frm_err, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule